// File: doc/BRIEF.md
# Programmable Sum-of-Products Macrocell Array

This block is a configurable logic array. Twelve dedicated inputs and ten macrocells feed one AND plane. Each product term is the AND of any chosen mix of true and inverted array signals. The array signals are the twelve inputs plus one feedback signal from each macrocell. Each macrocell ORs its own group of product terms, and the group sizes differ from one macrocell to the next. The resulting sum goes to an output stage that is set per macrocell as registered or combinational, and as active-high or active-low. A separate product term per macrocell drives that pin's output enable. Two global product terms act on all ten registers: one gives an asynchronous clear and the other a synchronous preset.

The complete personality of the array arrives as one flat configuration vector. It is captured on every clock edge while the synchronous active-low reset is held, and it stays frozen once reset is released. The surrounding logic drives the pin-side tristate buffers from `io_o` and `io_oe_o`. It returns the resolved pad levels on `io_pad_i`, which supply the feedback for combinational macrocells.

Top module: `sop_array`

## Requirements
- R1: The configuration vector `cfg_i` is captured on each rising clock edge while `rst_n` is low. While `rst_n` is high, changes on `cfg_i` have no effect on the outputs.
- R2: Array signal k is `in_i[k]` for k = 0..11 and the feedback of macrocell m for k = 12+m. Product term t owns configuration bits [t*44 +: 44]. Within that field, bit 2k set connects signal k true and bit 2k+1 set connects signal k inverted. A term is the AND of its connected literals. A term that connects both forms of one signal is 0, and a term with no connection is 0.
- R3: Macrocell m owns 8, 10, 12, 14, 16, 16, 14, 12, 10, 8 product terms for m = 0..9. Term 0 is the global asynchronous clear and term 131 is the global synchronous preset. Macrocell 0's group starts at term 1, and each group is its output-enable term followed by its sum terms. The sum is the OR of all of the macrocell's sum terms, including the last one.
- R4: `io_oe_o[m]` equals macrocell m's output-enable term, so an unconnected enable term leaves the pin undriven.
- R5: While `rst_n` is low, every register is cleared on the clock edge. A registered active-high pin then reads 0 and a registered active-low pin reads 1.
- R6: While the clear term is 1, every register reads 0 immediately, with no clock edge needed. It wins over the preset, and the registers stay at 0 after the clear ends until the next edge.
- R7: When the preset term is 1 and the clear term is 0, every register becomes 1 on the next edge, whatever its sum input is.
- R8: The mode bits of macrocell m are at 5808+2m (1 = registered) and 5809+2m (1 = active-low). In registered mode, the register loads the sum on each edge, the pin shows the register value inverted when active-low, and the feedback is the register value.
- R9: In combinational mode, the pin shows the sum in the same cycle, inverted when active-low, and the feedback is `io_pad_i[m]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all macrocell registers and the configuration store |
| rst_n | input | 1 | Synchronous active-low reset; loads configuration and clears registers |
| cfg_i | input | CFG_W (5828) | Flat configuration vector: fuse fields for all terms, then mode bits |
| in_i | input | 12 | Dedicated logic inputs |
| io_pad_i | input | 10 | Resolved pad levels, used as feedback by combinational macrocells |
| io_o | output | 10 | Per-macrocell pin data after polarity selection |
| io_oe_o | output | 10 | Per-macrocell output enable |

## Verification
One configuration sets each macrocell to a different role. The combinational cells are driven through single-literal, two-literal and inverted-literal terms. These patterns separate the AND of a term from the OR across terms and show whether a complemented fuse column is decoded correctly. A self-contradicting term and the very last term of the widest and the final group are exercised to expose off-by-one errors in the term layout. The registered cells are walked through load, preset, clear without a clock, and clear together with preset, which separates the three priorities. Pad-driven feedback and a configuration change after reset separate pin feedback from register feedback and a frozen store from a live one.

// File: rtl/sop_pkg.sv
`timescale 1ns/1ps
// Shared types and layout functions for the sum-of-products array.
// Assumes groups grow by a fixed step toward the middle macrocells and
// shrink symmetrically, and that term 0 and the last term are global.
package sop_pkg;

    // Per-macrocell output-stage mode, bit 0 = registered, bit 1 = inverted.
    typedef struct packed {
        logic inv;
        logic reg_mode;
    } mc_mode_t;

    // Number of sum terms owned by macrocell m.
    function automatic int pt_count(input int m, input int n_mc,
                                    input int pt_min, input int pt_step);
        int d;
        d = (m < n_mc - 1 - m) ? m : n_mc - 1 - m;
        return pt_min + pt_step * d;
    endfunction

    // Index of macrocell m's output-enable term; sum terms follow it.
    function automatic int pt_base(input int m, input int n_mc,
                                   input int pt_min, input int pt_step);
        int b;
        b = 1;
        for (int j = 0; j < m; j++) begin
            b += 1 + pt_count(j, n_mc, pt_min, pt_step);
        end
        return b;
    endfunction

    // Total product terms including the two global ones.
    function automatic int pt_total(input int n_mc, input int pt_min,
                                    input int pt_step);
        return pt_base(n_mc, n_mc, pt_min, pt_step) + 1;
    endfunction

    // Width of the flat configuration vector.
    function automatic int cfg_width(input int n_in, input int n_mc,
                                     input int pt_min, input int pt_step);
        return pt_total(n_mc, pt_min, pt_step) * 2 * (n_in + n_mc) + 2 * n_mc;
    endfunction

endpackage

// File: rtl/sop_cfg_store.sv
`timescale 1ns/1ps
// Configuration holding register.
// Samples the incoming configuration on every edge while reset is low and
// keeps it unchanged afterwards. Assumes the source is stable during reset.
module sop_cfg_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cfg_i,
    output logic [W-1:0] cfg_o
);

    // Capture the configuration only while held in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o <= cfg_i;
        end
    end

    // R1: once out of reset for a full cycle, the stored image never moves.
    assert_cfg_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg_o));

endmodule

// File: rtl/sop_pterm.sv
`timescale 1ns/1ps
// One AND-plane product term.
// Each literal is enabled by its own fuse bit; an enabled literal must be 1
// for the term to be 1. A term with no enabled literal is forced to 0.
module sop_pterm #(
    parameter int N_LIT = 44
) (
    input  logic [N_LIT-1:0] lit_i,
    input  logic [N_LIT-1:0] fuse_i,
    output logic             term_o
);

    logic any_fuse;
    logic all_met;

    // Detect a term that has at least one connection.
    always_comb any_fuse = |fuse_i;

    // Every connected literal must be high; open fuses are don't-care.
    always_comb all_met = &(lit_i | ~fuse_i);

    // Disabled terms contribute nothing.
    always_comb term_o = any_fuse & all_met;

endmodule

// File: rtl/sop_macrocell.sv
`timescale 1ns/1ps
// Output macrocell: OR of its sum terms, one register with asynchronous
// clear and synchronous preset, polarity and registered/combinational
// selection, and feedback selection. Assumes clr_i is free of glitches
// while the register holds state that matters.
module sop_macrocell #(
    parameter int N_TERMS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic                pre_i,
    input  sop_pkg::mc_mode_t   mode_i,
    input  logic [N_TERMS-1:0]  term_i,
    input  logic                oe_term_i,
    input  logic                pad_i,
    output logic                pin_o,
    output logic                oe_o,
    output logic                fb_o
);

    logic sum;
    logic state_q;
    logic stage;

    // OR across this cell's product terms.
    always_comb sum = |term_i;

    // Register: clear beats reset beats preset beats data.
    always_ff @(posedge clk or posedge clr_i) begin
        if (clr_i) begin
            state_q <= 1'b0;
        end else if (!rst_n) begin
            state_q <= 1'b0;
        end else if (pre_i) begin
            state_q <= 1'b1;
        end else begin
            state_q <= sum;
        end
    end

    // Pick registered or combinational value for the pin.
    always_comb stage = mode_i.reg_mode ? state_q : sum;

    // Apply the selected output polarity.
    always_comb pin_o = stage ^ mode_i.inv;

    // Output enable comes straight from the dedicated term.
    always_comb oe_o = oe_term_i;

    // Feedback: register in registered mode, pad level otherwise.
    always_comb fb_o = mode_i.reg_mode ? state_q : pad_i;

    // R6: a clear seen at an edge has already emptied the register.
    assert_clear_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |-> (state_q == 1'b0));

    // R7: preset without clear sets the register on the next edge.
    assert_preset_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_i && !clr_i) |=> (state_q || clr_i));

    // R8: with neither global term active the register follows the sum.
    assert_load_sum_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pre_i && !clr_i) |=> (clr_i || (state_q == $past(sum))));

endmodule

// File: rtl/sop_array.sv
`timescale 1ns/1ps
// Top of the programmable sum-of-products array.
// Builds the literal vector from inputs and macrocell feedback, evaluates
// every product term from the stored configuration, and distributes term
// groups to the macrocells. Assumes combinational feedback returns through
// io_pad_i from outside.
module sop_array #(
    parameter int N_IN    = 12,
    parameter int N_MC    = 10,
    parameter int PT_MIN  = 8,
    parameter int PT_STEP = 2,
    parameter int CFG_W   = sop_pkg::cfg_width(N_IN, N_MC, PT_MIN, PT_STEP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic [N_IN-1:0]  in_i,
    input  logic [N_MC-1:0]  io_pad_i,
    output logic [N_MC-1:0]  io_o,
    output logic [N_MC-1:0]  io_oe_o
);

    localparam int N_SIG     = N_IN + N_MC;
    localparam int N_LIT     = 2 * N_SIG;
    localparam int N_PT      = sop_pkg::pt_total(N_MC, PT_MIN, PT_STEP);
    localparam int TERM_BITS = N_PT * N_LIT;
    localparam int CLR_IDX   = 0;
    localparam int PRE_IDX   = N_PT - 1;

    logic [CFG_W-1:0] cfg_q;
    logic [N_MC-1:0]  fb;
    logic [N_SIG-1:0] sig;
    logic [N_LIT-1:0] lit;
    logic [N_PT-1:0]  pt;

    // Frozen configuration image.
    sop_cfg_store #(.W(CFG_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .cfg_i (cfg_i),
        .cfg_o (cfg_q)
    );

    // Array signals: inputs low, feedback high.
    always_comb sig = {fb, in_i};

    // True and complement literal per array signal.
    for (genvar k = 0; k < N_SIG; k++) begin : g_lit
        assign lit[2*k]   = sig[k];
        assign lit[2*k+1] = ~sig[k];
    end

    // Every product term, each with its own fuse field.
    for (genvar t = 0; t < N_PT; t++) begin : g_pt
        sop_pterm #(.N_LIT(N_LIT)) u_pt (
            .lit_i  (lit),
            .fuse_i (cfg_q[t*N_LIT +: N_LIT]),
            .term_o (pt[t])
        );
    end

    // Macrocells, each handed its enable term and its sum-term group.
    for (genvar m = 0; m < N_MC; m++) begin : g_mc
        localparam int BASE = sop_pkg::pt_base(m, N_MC, PT_MIN, PT_STEP);
        localparam int CNT  = sop_pkg::pt_count(m, N_MC, PT_MIN, PT_STEP);
        sop_pkg::mc_mode_t mode_m;

        assign mode_m = sop_pkg::mc_mode_t'(cfg_q[TERM_BITS + 2*m +: 2]);

        sop_macrocell #(.N_TERMS(CNT)) u_mc (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_i     (pt[CLR_IDX]),
            .pre_i     (pt[PRE_IDX]),
            .mode_i    (mode_m),
            .term_i    (pt[BASE+1 +: CNT]),
            .oe_term_i (pt[BASE]),
            .pad_i     (io_pad_i[m]),
            .pin_o     (io_o[m]),
            .oe_o      (io_oe_o[m]),
            .fb_o      (fb[m])
        );
    end

endmodule

// File: tb/sop_array_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected pin values, the monitor
// pops and compares them against the live outputs.
module sop_array_bench;

    localparam int NI  = 12;
    localparam int NM  = 10;
    localparam int NL  = 2 * (NI + NM);
    localparam int NPT = 132;
    localparam int CW  = NPT * NL + 2 * NM;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cfg_i = '0;
    logic [NI-1:0] in_i  = '0;
    logic [NM-1:0] pad   = '0;
    logic [NM-1:0] io_o;
    logic [NM-1:0] io_oe;
    logic [CW-1:0] cfg_a = '0;

    typedef struct {
        logic [NM-1:0] mo;
        logic [NM-1:0] eo;
        logic [NM-1:0] moe;
        logic [NM-1:0] eoe;
        string         tag;
    } item_t;

    item_t exp_q[$];
    event  chk_ev;
    int    compared   = 0;
    int    mismatched = 0;
    bit    done       = 1'b0;

    always #4 clk = ~clk;

    sop_array u_sop_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_i    (cfg_i),
        .in_i     (in_i),
        .io_pad_i (pad),
        .io_o     (io_o),
        .io_oe_o  (io_oe)
    );

    // Layout as stated in R2/R3/R8.
    function automatic int cnt(input int m);
        int d;
        d = (m < NM - 1 - m) ? m : NM - 1 - m;
        return 8 + 2 * d;
    endfunction

    function automatic int base(input int m);
        int b;
        b = 1;
        for (int j = 0; j < m; j++) b += 1 + cnt(j);
        return b;
    endfunction

    task automatic link(input int t, input int k, input int neg);
        cfg_a[t*NL + 2*k + neg] = 1'b1;
    endtask

    task automatic set_mode(input int m, input bit r, input bit inv);
        cfg_a[NPT*NL + 2*m]     = r;
        cfg_a[NPT*NL + 2*m + 1] = inv;
    endtask

    // Driver side: queue one expectation and hand it to the monitor.
    task automatic chk(input logic [NM-1:0] mo, input logic [NM-1:0] eo,
                       input logic [NM-1:0] moe, input logic [NM-1:0] eoe,
                       input string tag);
        item_t it;
        #1;
        it.mo = mo; it.eo = eo; it.moe = moe; it.eoe = eoe; it.tag = tag;
        exp_q.push_back(it);
        -> chk_ev;
        #1;
    endtask

    task automatic post_edge();
        @(posedge clk);
        #2;
    endtask

    // Monitor: pop and compare under the masks.
    initial begin
        forever begin
            item_t it;
            @(chk_ev);
            it = exp_q.pop_front();
            compared++;
            if ((((io_o ^ it.eo) & it.mo) != '0) || (((io_oe ^ it.eoe) & it.moe) != '0)) begin
                mismatched++;
                $display("FAIL %s: io_o=%b io_oe=%b expected io_o=%b io_oe=%b (masks %b %b)",
                         it.tag, io_o, io_oe, it.eo, it.eoe, it.mo, it.moe);
            end
        end
    end

    // Watchdog.
    initial begin
        #(8 * 20000);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    localparam logic [NM-1:0] ALL  = 10'b11_1111_1111;
    localparam logic [NM-1:0] NONE = 10'b00_0000_0000;
    localparam logic [NM-1:0] REGS = 10'b10_0000_1100;

    initial begin
        // Enable term = in11 for cells 0..6 and 9.
        for (int m = 0; m < NM; m++) if (m < 7 || m == 9) link(base(m), 11, 0);
        link(base(0)+1, 0, 0); link(base(0)+1, 1, 0);
        link(base(0)+2, 2, 0); link(base(0)+2, 3, 1);
        link(base(1)+1, 4, 0);          set_mode(1, 1'b0, 1'b1);
        link(base(2)+1, 5, 0);          set_mode(2, 1'b1, 1'b0);
        link(base(3)+1, 6, 0);          set_mode(3, 1'b1, 1'b1);
        link(base(4)+1, 0, 0); link(base(4)+1, 0, 1);
        link(base(4)+cnt(4), 7, 0);
        link(base(5)+cnt(5), 8, 0); link(base(5)+cnt(5), 14, 0);
        link(base(6)+1, 19, 0);
        link(base(9)+cnt(9), 9, 0);     set_mode(9, 1'b1, 1'b0);
        link(0, 10, 0);
        link(NPT-1, 8, 0); link(NPT-1, 9, 0);
        cfg_i = cfg_a;

        repeat (3) @(posedge clk);
        #2;
        chk(REGS, 10'b00_0000_1000, ALL, NONE, "R5 registers cleared in reset");

        @(negedge clk); rst_n = 1'b1; in_i[11] = 1'b1;
        chk(NONE, NONE, ALL, 10'b10_0111_1111, "R4 enable terms on");
        chk(10'b00_0000_0010, 10'b00_0000_0010, NONE, NONE, "R9 active-low comb with in4=0");

        @(negedge clk); in_i[0] = 1'b1; in_i[1] = 1'b1;
        chk(10'b1, 10'b1, NONE, NONE, "R2 two-literal AND true");
        @(negedge clk); in_i[1] = 1'b0;
        chk(10'b1, 10'b0, NONE, NONE, "R2 AND with one literal low");
        chk(10'b1_0000, 10'b0, NONE, NONE, "R2 contradictory term with in0=1");
        @(negedge clk); in_i[2] = 1'b1;
        chk(10'b1, 10'b1, NONE, NONE, "R3 OR picks second term");
        @(negedge clk); in_i[3] = 1'b1;
        chk(10'b1, 10'b0, NONE, NONE, "R2 inverted literal blocks term");
        @(negedge clk); in_i[4] = 1'b1; in_i[0] = 1'b0;
        chk(10'b11_0010, 10'b0, NONE, NONE, "R9/R2 inverted comb pin and contradictory term");
        @(negedge clk); in_i[7] = 1'b1;
        chk(10'b1_0000, 10'b1_0000, NONE, NONE, "R3 last term of widest group");
        @(negedge clk); in_i[7] = 1'b0;

        // Registered load.
        @(negedge clk); in_i[5] = 1'b1; in_i[6] = 1'b1; in_i[9] = 1'b1;
        chk(REGS, 10'b00_0000_1000, NONE, NONE, "R8 no change before edge");
        post_edge();
        chk(REGS, 10'b10_0000_0100, NONE, NONE, "R8 load incl. last term of last group");
        @(negedge clk); in_i[9] = 1'b0; in_i[8] = 1'b1;
        chk(10'b10_0000, 10'b10_0000, NONE, NONE, "R8 register feedback into array");
        post_edge();
        chk(REGS, 10'b00_0000_0100, NONE, NONE, "R8 load zero into cell 9");
        @(negedge clk); in_i[5] = 1'b0;
        post_edge();
        chk(10'b10_0100, 10'b0, NONE, NONE, "R8 feedback follows register low");

        // Preset.
        @(negedge clk); in_i[6] = 1'b0; in_i[9] = 1'b1;
        post_edge();
        chk(REGS, 10'b10_0000_0100, NONE, NONE, "R7 preset overrides data");
        @(negedge clk); in_i[8] = 1'b0; in_i[9] = 1'b0;
        post_edge();
        chk(REGS, 10'b00_0000_1000, NONE, NONE, "R8 data after preset ends");

        // Asynchronous clear.
        @(negedge clk); in_i[5] = 1'b1;
        post_edge();
        chk(10'b100, 10'b100, NONE, NONE, "R8 cell 2 loaded high");
        @(negedge clk); in_i[10] = 1'b1;
        chk(REGS, 10'b00_0000_1000, NONE, NONE, "R6 clear without edge");
        @(negedge clk); in_i[8] = 1'b1; in_i[9] = 1'b1;
        post_edge();
        chk(REGS, 10'b00_0000_1000, NONE, NONE, "R6 clear beats preset");
        @(negedge clk); in_i[10] = 1'b0; in_i[8] = 1'b0; in_i[9] = 1'b0;
        chk(REGS, 10'b00_0000_1000, NONE, NONE, "R6 stays clear until edge");

        // Pad feedback for combinational cells.
        @(negedge clk); pad[7] = 1'b1;
        chk(10'b100_0000, 10'b100_0000, 10'b1000_0000, NONE, "R9/R4 pad feedback, unconnected enable");
        @(negedge clk); pad[7] = 1'b0;
        chk(10'b100_0000, 10'b0, NONE, NONE, "R9 pad feedback low");
        @(negedge clk); in_i[11] = 1'b0;
        chk(NONE, NONE, ALL, NONE, "R4 enable terms off");

        // Configuration freeze, then reload.
        @(negedge clk); cfg_i = '0; in_i[11] = 1'b1; in_i[0] = 1'b1; in_i[1] = 1'b1;
        post_edge(); post_edge();
        chk(10'b1, 10'b1, 10'b1, 10'b1, "R1 configuration change ignored");
        @(negedge clk); rst_n = 1'b0;
        post_edge();
        chk(ALL, NONE, ALL, NONE, "R1/R5 reload of empty configuration");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule